// File: doc/BRIEF.md
# Shared-Memory Ring Buffer Accessor

This block gives a host engine byte-level get and put access to ring buffers that live in the memory of another processor. Each ring keeps three control bytes just below its base address: an index mask, a producer index and a consumer index. The accessor holds a local descriptor per ring (base address, mask, producer index, consumer index). Before each transfer it fetches the index the far side owns, so the two processors can share the ring without any other coordination.

Every access to foreign memory is wrapped in a bus lease: the block raises a bus request, waits for the grant, runs one or more single-byte read or write cycles through an external cycle port, then drops the request and waits for the grant to go away. The host issues one operation at a time through a valid/ready request channel and receives a one-cycle response carrying a flag and a data byte. A get waits while the ring is empty and a put waits while it is full, taking a fresh lease for each re-poll.

Top module: `shring_access`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, bus_req is 0 and cyc_valid is 0, and every ring descriptor has base address zero.
- R2: Ring control bytes are addressed relative to the base: mask at base-3, producer index at base-2, consumer index at base-1, and data slot k at base+k.
- R3: Operation code 0 (init) stores req_base for ring req_ring and, within a single lease, reads the mask, the producer index and the consumer index (three cycles) into the local descriptor; the response flag is 0.
- R4: Operation code 3 (empty query) takes one lease with one read of the producer index and answers flag 1 exactly when it equals the local consumer index.
- R5: Operation code 4 (full query) takes one lease with one read of the consumer index and answers flag 1 exactly when (local producer index + 1) AND mask equals it.
- R6: Operation code 2 (get) polls as in R4, each poll in its own lease, until the ring is not empty; then in a second lease it reads the slot at the local consumer index, writes (consumer + 1) AND mask to base-1 and keeps that value locally; rsp_data is the byte read and the flag is 0.
- R7: Operation code 1 (put) polls as in R5, each poll in its own lease, until the ring is not full; then in a second lease it writes req_data to the slot at the local producer index, writes (producer + 1) AND mask to base-2 and keeps that value locally; the flag is 0.
- R8: An operation other than init on a ring whose base is zero, and any operation code from 5 to 7, is answered one cycle after acceptance with flag 1 and without raising bus_req.
- R9: A bus cycle is only presented while bus_req and bus_gnt are both high, and every lease ends with bus_req low and bus_gnt seen low before the response or the next lease.
- R10: Once cyc_valid is raised, cyc_valid, cyc_wr, cyc_addr and cyc_wdata stay unchanged until the cycle in which cyc_done is high.
- R11: Operations on one ring leave the descriptors of all other rings unchanged.
- R12: rsp_valid is a single-cycle pulse, and req_ready is 0 from acceptance until the response has been given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | Operation code: 0 init, 1 put, 2 get, 3 empty, 4 full |
| req_ring | input | SEL_W | Ring descriptor select |
| req_base | input | ADDR_W | Ring base address (init only) |
| req_data | input | 8 | Byte to store (put only) |
| rsp_valid | output | 1 | Response pulse |
| rsp_flag | output | 1 | Query result, or 1 when refused |
| rsp_data | output | 8 | Byte fetched by a get |
| bus_req | output | 1 | Foreign bus request |
| bus_gnt | input | 1 | Foreign bus grant |
| cyc_valid | output | 1 | Bus cycle requested |
| cyc_wr | output | 1 | 1 write, 0 read |
| cyc_addr | output | ADDR_W | Bus cycle address |
| cyc_wdata | output | 8 | Write data |
| cyc_done | input | 1 | Cycle completed (one-cycle pulse) |
| cyc_rdata | input | 8 | Read data, valid with cyc_done |

## Verification
The assertions take for granted that the bus arbiter keeps bus_gnt high for as long as bus_req stays high once it has granted, that bus_gnt falls only after bus_req has fallen, and that cyc_done pulses for one cycle and only while a cycle is pending. The bench bus model follows exactly that discipline: the grant tracks the request two cycles late, and the cycle responder completes each cycle after a fixed latency from a byte array. The far processor is imitated by writing ring bytes directly into that array while a get or put is still polling, and the mask values used are always a power of two minus one, so indices written back stay inside the mask.

// File: rtl/shring_pkg.sv
package shring_pkg;

    localparam int IDX_W    = 8;
    localparam int OFS_MASK = 3;
    localparam int OFS_PROD = 2;
    localparam int OFS_CONS = 1;

    typedef enum logic [2:0] {
        OP_INIT  = 3'd0,
        OP_PUT   = 3'd1,
        OP_GET   = 3'd2,
        OP_EMPTY = 3'd3,
        OP_FULL  = 3'd4
    } ring_op_e;

    typedef enum logic [2:0] {
        LOC_MASK,
        LOC_PROD,
        LOC_CONS,
        LOC_SLOT_RD,
        LOC_SLOT_WR
    } loc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_ISSUE,
        ST_WAIT,
        ST_REL,
        ST_DECIDE,
        ST_RESP
    } seq_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] mask;
        logic [IDX_W-1:0] prod;
        logic [IDX_W-1:0] cons;
    } ring_idx_t;

    typedef struct packed {
        logic wr;
        loc_e loc;
        logic last;
    } cyc_step_t;

    function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] idx,
                                                   input logic [IDX_W-1:0] mask);
        return (idx + IDX_W'(1)) & mask;
    endfunction

    function automatic logic op_is_legal(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    // Cycle programme of one lease: which location, direction, and whether
    // this is the final cycle before the lease is returned.
    function automatic cyc_step_t plan_step(input ring_op_e op,
                                            input logic xfer,
                                            input logic [1:0] step);
        cyc_step_t s;
        s.wr   = 1'b0;
        s.loc  = LOC_MASK;
        s.last = 1'b1;
        case (op)
            OP_INIT: begin
                s.loc  = (step == 2'd0) ? LOC_MASK :
                         (step == 2'd1) ? LOC_PROD : LOC_CONS;
                s.last = (step == 2'd2);
            end
            OP_EMPTY: s.loc = LOC_PROD;
            OP_FULL:  s.loc = LOC_CONS;
            OP_GET: begin
                if (!xfer) begin
                    s.loc = LOC_PROD;
                end else begin
                    s.wr   = step[0];
                    s.loc  = step[0] ? LOC_CONS : LOC_SLOT_RD;
                    s.last = step[0];
                end
            end
            OP_PUT: begin
                if (!xfer) begin
                    s.loc = LOC_CONS;
                end else begin
                    s.wr   = 1'b1;
                    s.loc  = step[0] ? LOC_PROD : LOC_SLOT_WR;
                    s.last = step[0];
                end
            end
            default: s.last = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/shring_desc_bank.sv
module shring_desc_bank
    import shring_pkg::*;
#(
    parameter int NUM_RINGS = 4,
    parameter int ADDR_W    = 20,
    localparam int SEL_W    = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [ADDR_W-1:0] rd_base,
    output ring_idx_t        rd_idx,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [ADDR_W-1:0] wr_base,
    input  ring_idx_t        wr_idx
);

    logic [ADDR_W-1:0] base_all [NUM_RINGS];
    ring_idx_t         idx_all  [NUM_RINGS];

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ent
        logic [ADDR_W-1:0] base_e;
        ring_idx_t         idx_e;

        always_ff @(posedge clk) begin
            if (rst) begin
                base_e <= '0;
                idx_e  <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                base_e <= wr_base;
                idx_e  <= wr_idx;
            end
        end

        assign base_all[g] = base_e;
        assign idx_all[g]  = idx_e;
    end

    always_comb begin
        rd_base = '0;
        rd_idx  = '0;
        if (int'(rd_sel) < NUM_RINGS) begin
            rd_base = base_all[rd_sel];
            rd_idx  = idx_all[rd_sel];
        end
    end

endmodule

// File: rtl/shring_bus_lease.sv
module shring_bus_lease (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic bus_gnt,
    output logic bus_req,
    output logic held,
    output logic free
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req <= 1'b0;
        end else begin
            bus_req <= want;
        end
    end

    assign held = bus_req & bus_gnt;
    assign free = ~bus_req & ~bus_gnt;

endmodule

// File: rtl/shring_cyc_issue.sv
module shring_cyc_issue #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              cyc_done,
    output logic              cyc_valid,
    output logic              cyc_wr,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_wdata,
    output logic              fin
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_valid <= 1'b0;
            cyc_wr    <= 1'b0;
            cyc_addr  <= '0;
            cyc_wdata <= '0;
        end else if (start) begin
            cyc_valid <= 1'b1;
            cyc_wr    <= wr_in;
            cyc_addr  <= addr_in;
            cyc_wdata <= wdata_in;
        end else if (cyc_valid && cyc_done) begin
            cyc_valid <= 1'b0;
        end
    end

    assign fin = cyc_valid & cyc_done;

    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && !cyc_done) |=> (cyc_valid && $stable(cyc_wr) &&
                                      $stable(cyc_addr) && $stable(cyc_wdata))); // R10

endmodule

// File: rtl/shring_access.sv
module shring_access
    import shring_pkg::*;
#(
    parameter int NUM_RINGS = 4,
    parameter int ADDR_W    = 20,
    localparam int SEL_W    = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [SEL_W-1:0]  req_ring,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [7:0]        req_data,
    output logic              rsp_valid,
    output logic              rsp_flag,
    output logic [7:0]        rsp_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              cyc_valid,
    output logic              cyc_wr,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [7:0]        cyc_wdata,
    input  logic              cyc_done,
    input  logic [7:0]        cyc_rdata
);

    seq_state_e        state;
    ring_op_e          op_q;
    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] base_q;
    ring_idx_t         idx_q;
    logic [IDX_W-1:0]  data_q;
    logic [IDX_W-1:0]  peer_q;
    logic              xfer_q;
    logic [1:0]        step_q;
    logic              flag_q;
    logic              wb_q;

    logic [ADDR_W-1:0] rd_base;
    ring_idx_t         rd_idx;
    logic              want, held, free, start, fin;
    cyc_step_t         step;
    logic [IDX_W-1:0]  nxt_prod, nxt_cons;
    logic [ADDR_W-1:0] step_addr;
    logic [IDX_W-1:0]  step_wdata;
    logic              ring_empty, ring_full;

    shring_desc_bank #(.NUM_RINGS(NUM_RINGS), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .rd_sel  (req_ring),
        .rd_base (rd_base),
        .rd_idx  (rd_idx),
        .wr_en   (state == ST_RESP && wb_q),
        .wr_sel  (sel_q),
        .wr_base (base_q),
        .wr_idx  (idx_q)
    );

    shring_bus_lease u_lease (
        .clk     (clk),
        .rst     (rst),
        .want    (want),
        .bus_gnt (bus_gnt),
        .bus_req (bus_req),
        .held    (held),
        .free    (free)
    );

    shring_cyc_issue #(.ADDR_W(ADDR_W), .DATA_W(IDX_W)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wr_in     (step.wr),
        .addr_in   (step_addr),
        .wdata_in  (step_wdata),
        .cyc_done  (cyc_done),
        .cyc_valid (cyc_valid),
        .cyc_wr    (cyc_wr),
        .cyc_addr  (cyc_addr),
        .cyc_wdata (cyc_wdata),
        .fin       (fin)
    );

    // Cycle programme and address / data for the current step
    always_comb begin
        step     = plan_step(op_q, xfer_q, step_q);
        nxt_prod = ring_next(idx_q.prod, idx_q.mask);
        nxt_cons = ring_next(idx_q.cons, idx_q.mask);
        case (step.loc)
            LOC_MASK:    step_addr = base_q - ADDR_W'(OFS_MASK);
            LOC_PROD:    step_addr = base_q - ADDR_W'(OFS_PROD);
            LOC_CONS:    step_addr = base_q - ADDR_W'(OFS_CONS);
            LOC_SLOT_RD: step_addr = base_q + ADDR_W'(idx_q.cons);
            LOC_SLOT_WR: step_addr = base_q + ADDR_W'(idx_q.prod);
            default:     step_addr = base_q;
        endcase
        case (step.loc)
            LOC_PROD:    step_wdata = nxt_prod;
            LOC_CONS:    step_wdata = nxt_cons;
            LOC_SLOT_WR: step_wdata = data_q;
            default:     step_wdata = '0;
        endcase
        ring_empty = (peer_q == idx_q.cons);
        ring_full  = (nxt_prod == peer_q);
    end

    assign req_ready = (state == ST_IDLE);
    assign want      = (state == ST_ACQ) || (state == ST_ISSUE) || (state == ST_WAIT);
    assign start     = (state == ST_ISSUE);
    assign rsp_valid = (state == ST_RESP);
    assign rsp_flag  = flag_q;
    assign rsp_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= OP_INIT;
            sel_q  <= '0;
            base_q <= '0;
            idx_q  <= '0;
            data_q <= '0;
            peer_q <= '0;
            xfer_q <= 1'b0;
            step_q <= '0;
            flag_q <= 1'b0;
            wb_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q   <= ring_op_e'(req_op);
                        sel_q  <= req_ring;
                        data_q <= req_data;
                        peer_q <= '0;
                        xfer_q <= 1'b0;
                        step_q <= '0;
                        idx_q  <= rd_idx;
                        if (req_op == OP_INIT) begin
                            base_q <= req_base;
                            flag_q <= 1'b0;
                            wb_q   <= 1'b0;
                            state  <= ST_ACQ;
                        end else if (op_is_legal(req_op) && rd_base != '0) begin
                            base_q <= rd_base;
                            flag_q <= 1'b0;
                            wb_q   <= 1'b0;
                            state  <= ST_ACQ;
                        end else begin
                            base_q <= rd_base;
                            flag_q <= 1'b1;
                            wb_q   <= 1'b0;
                            state  <= ST_RESP;
                        end
                    end
                end
                ST_ACQ: begin
                    if (held) begin
                        state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (fin) begin
                        if (!step.wr) begin
                            case (step.loc)
                                LOC_MASK: idx_q.mask <= cyc_rdata;
                                LOC_PROD: begin
                                    if (op_q == OP_INIT) idx_q.prod <= cyc_rdata;
                                    else                 peer_q     <= cyc_rdata;
                                end
                                LOC_CONS: begin
                                    if (op_q == OP_INIT) idx_q.cons <= cyc_rdata;
                                    else                 peer_q     <= cyc_rdata;
                                end
                                LOC_SLOT_RD: data_q <= cyc_rdata;
                                default: ;
                            endcase
                        end else begin
                            case (step.loc)
                                LOC_PROD: idx_q.prod <= nxt_prod;
                                LOC_CONS: idx_q.cons <= nxt_cons;
                                default: ;
                            endcase
                        end
                        if (step.last) begin
                            state <= ST_REL;
                        end else begin
                            step_q <= step_q + 2'd1;
                            state  <= ST_ISSUE;
                        end
                    end
                end
                ST_REL: begin
                    if (free) begin
                        state <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    step_q <= '0;
                    case (op_q)
                        OP_INIT: begin
                            wb_q  <= 1'b1;
                            state <= ST_RESP;
                        end
                        OP_EMPTY: begin
                            flag_q <= ring_empty;
                            state  <= ST_RESP;
                        end
                        OP_FULL: begin
                            flag_q <= ring_full;
                            state  <= ST_RESP;
                        end
                        OP_GET: begin
                            if (xfer_q) begin
                                wb_q  <= 1'b1;
                                state <= ST_RESP;
                            end else begin
                                xfer_q <= ~ring_empty;
                                state  <= ST_ACQ;
                            end
                        end
                        OP_PUT: begin
                            if (xfer_q) begin
                                wb_q  <= 1'b1;
                                state <= ST_RESP;
                            end else begin
                                xfer_q <= ~ring_full;
                                state  <= ST_ACQ;
                            end
                        end
                        default: state <= ST_RESP;
                    endcase
                end
                ST_RESP: begin
                    wb_q  <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_CYC_LEASED: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |-> (bus_req && bus_gnt)); // R9

    AST_RSP_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!bus_req && !bus_gnt)); // R9

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R12

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready); // R12

    AST_REFUSE_FAST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op != 3'd0 &&
         (rd_base == '0 || req_op > 3'd4)) |=> (rsp_valid && rsp_flag && !bus_req)); // R8

endmodule

// File: tb/shring_access_test.sv
`timescale 1ns/1ps
module shring_access_test;

    localparam int AW = 12;
    localparam logic [2:0] C_INIT = 3'd0, C_PUT = 3'd1, C_GET = 3'd2,
                           C_EMPTY = 3'd3, C_FULL = 3'd4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [1:0]    req_ring = '0;
    logic [AW-1:0] req_base = '0;
    logic [7:0]    req_data = '0;
    logic          rsp_valid, rsp_flag;
    logic [7:0]    rsp_data;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          cyc_valid, cyc_wr;
    logic [AW-1:0] cyc_addr;
    logic [7:0]    cyc_wdata;
    logic          cyc_done = 1'b0;
    logic [7:0]    cyc_rdata = '0;

    shring_access #(.NUM_RINGS(4), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_ring(req_ring), .req_base(req_base), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_flag(rsp_flag), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .cyc_valid(cyc_valid), .cyc_wr(cyc_wr), .cyc_addr(cyc_addr),
        .cyc_wdata(cyc_wdata), .cyc_done(cyc_done), .cyc_rdata(cyc_rdata)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int n_lease = 0;
    int n_cyc = 0;
    int n_bad_lease = 0;
    int n_unstable = 0;
    bit finished = 0;

    logic [7:0] mem [0:(1<<AW)-1];
    logic [9:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // Foreign bus model: grant trails request by two cycles, fixed-latency memory
    logic g1 = 1'b0;
    int   lat = 0;
    logic prev_req = 1'b0;
    logic hold_pend = 1'b0;
    logic [AW-1:0] h_addr;
    logic [7:0]    h_wdata;
    logic          h_wr;
    always @(posedge clk) begin
        if (rst) begin
            g1 <= 1'b0; bus_gnt <= 1'b0; cyc_done <= 1'b0; lat <= 0;
            prev_req <= 1'b0; hold_pend <= 1'b0;
        end else begin
            g1 <= bus_req;
            bus_gnt <= g1;
            prev_req <= bus_req;
            if (bus_req && !prev_req) n_lease <= n_lease + 1;
            if (cyc_valid && !(bus_req && bus_gnt)) n_bad_lease <= n_bad_lease + 1;
            if (hold_pend && (!cyc_valid || cyc_addr != h_addr || cyc_wr != h_wr ||
                              cyc_wdata != h_wdata))
                n_unstable <= n_unstable + 1;
            hold_pend <= cyc_valid && !cyc_done;
            h_addr <= cyc_addr; h_wr <= cyc_wr; h_wdata <= cyc_wdata;
            if (cyc_valid && !cyc_done) begin
                if (lat == 2) begin
                    cyc_done  <= 1'b1;
                    cyc_rdata <= mem[cyc_addr];
                    if (cyc_wr) mem[cyc_addr] <= cyc_wdata;
                    lat   <= 0;
                    n_cyc <= n_cyc + 1;
                end else begin
                    lat <= lat + 1;
                end
            end else begin
                cyc_done <= 1'b0;
            end
        end
    end

    // Scoreboard monitor
    logic prev_rsp = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                logic [9:0] e;
                string t;
                check(prev_rsp == 1'b0, "R12 response pulse", 1, 0);
                check(!bus_req && !bus_gnt, "R9 lease returned before response",
                      {bus_req, bus_gnt}, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12 unexpected response", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rsp_flag == e[8], {t, " flag"}, rsp_flag, e[8]);
                    if (e[9]) check(rsp_data == e[7:0], {t, " data"}, rsp_data, e[7:0]);
                end
            end
            prev_rsp = rsp_valid;
        end
    end

    task automatic run_op(input logic [2:0] op, input logic [1:0] ring,
                          input logic [AW-1:0] base, input logic [7:0] d,
                          input bit ef, input bit chkd, input logic [7:0] ed,
                          input string tag);
        exp_q.push_back({chkd, ef, ed});
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_ring = ring; req_base = base; req_data = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R12 not ready while busy", req_ready, 0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    int l0, c0;

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
        // ring 0 at 0x100: mask 7, producer 0, consumer 0
        mem[12'h0FD] = 8'h07; mem[12'h0FE] = 8'h00; mem[12'h0FF] = 8'h00;
        // ring 1 at 0x200: mask 3, producer 2, consumer 2
        mem[12'h1FD] = 8'h03; mem[12'h1FE] = 8'h02; mem[12'h1FF] = 8'h02;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        check(bus_req == 1'b0, "R1 bus_req", bus_req, 0);
        check(cyc_valid == 1'b0, "R1 cyc_valid", cyc_valid, 0);

        // R8 refused on uninitialised ring, no lease
        l0 = n_lease;
        run_op(C_GET, 2'd0, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R1 R8 get before init");
        run_op(C_FULL, 2'd0, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R8 full before init");
        run_op(C_EMPTY, 2'd0, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R8 empty before init");
        check(n_lease == l0, "R8 no lease", n_lease - l0, 0);

        // R3 init ring 0
        l0 = n_lease; c0 = n_cyc;
        run_op(C_INIT, 2'd0, 12'h100, 8'h00, 1'b0, 1'b0, 8'h00, "R3 init ring0");
        check(n_lease - l0 == 1, "R3 init lease count", n_lease - l0, 1);
        check(n_cyc - c0 == 3, "R3 init cycle count", n_cyc - c0, 3);

        // R4 empty query, one cycle
        l0 = n_lease; c0 = n_cyc;
        run_op(C_EMPTY, 2'd0, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R4 empty ring0");
        check(n_cyc - c0 == 1 && n_lease - l0 == 1, "R4 one read one lease", n_cyc - c0, 1);

        // R7 R2 puts
        l0 = n_lease;
        for (int k = 0; k < 3; k++)
            run_op(C_PUT, 2'd0, '0, 8'hA1 + 8'(k), 1'b0, 1'b0, 8'h00, "R7 put");
        check(n_lease - l0 == 6, "R7 two leases per put", n_lease - l0, 6);
        for (int k = 0; k < 3; k++)
            check(mem[12'h100 + k] == 8'hA1 + 8'(k), "R2 R7 slot data", mem[12'h100 + k], 8'hA1 + 8'(k));
        check(mem[12'h0FE] == 8'h03, "R2 R7 producer index", mem[12'h0FE], 3);

        run_op(C_FULL, 2'd0, '0, 8'h00, 1'b0, 1'b0, 8'h00, "R5 not full");
        run_op(C_EMPTY, 2'd0, '0, 8'h00, 1'b0, 1'b0, 8'h00, "R4 not empty");
        for (int k = 0; k < 4; k++)
            run_op(C_PUT, 2'd0, '0, 8'hB4 + 8'(k), 1'b0, 1'b0, 8'h00, "R7 put fill");
        run_op(C_FULL, 2'd0, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R5 full at boundary");

        // R7 put waits while full, far side frees a slot
        fork
            run_op(C_PUT, 2'd0, '0, 8'hE7, 1'b0, 1'b0, 8'h00, "R7 put after wait");
            begin
                repeat (60) @(negedge clk);
                check(exp_q.size() == 1, "R7 put still waiting", exp_q.size(), 1);
                check(mem[12'h107] == 8'h00, "R7 no write while full", mem[12'h107], 0);
                mem[12'h0FF] = 8'h01;
            end
        join
        check(mem[12'h107] == 8'hE7, "R7 slot after wait", mem[12'h107], 8'hE7);
        check(mem[12'h0FE] == 8'h00, "R7 producer wraps", mem[12'h0FE], 0);

        // R6 get on ring 1
        run_op(C_INIT, 2'd1, 12'h200, 8'h00, 1'b0, 1'b0, 8'h00, "R3 init ring1");
        run_op(C_EMPTY, 2'd1, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R4 ring1 empty");
        fork
            run_op(C_GET, 2'd1, '0, 8'h00, 1'b0, 1'b1, 8'h5C, "R6 get after wait");
            begin
                repeat (60) @(negedge clk);
                check(exp_q.size() == 1, "R6 get still waiting", exp_q.size(), 1);
                mem[12'h202] = 8'h5C;
                mem[12'h1FE] = 8'h03;
            end
        join
        check(mem[12'h1FF] == 8'h03, "R6 consumer index written", mem[12'h1FF], 3);
        mem[12'h203] = 8'h77;
        mem[12'h1FE] = 8'h00;
        run_op(C_GET, 2'd1, '0, 8'h00, 1'b0, 1'b1, 8'h77, "R6 get wrap");
        check(mem[12'h1FF] == 8'h00, "R6 consumer wraps", mem[12'h1FF], 0);
        run_op(C_EMPTY, 2'd1, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R4 ring1 drained");
        run_op(C_FULL, 2'd1, '0, 8'h00, 1'b0, 1'b0, 8'h00, "R5 ring1 not full");

        // R11 ring 0 state kept across ring 1 activity
        run_op(C_FULL, 2'd0, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R11 ring0 full kept");
        l0 = n_lease;
        run_op(C_PUT, 2'd2, '0, 8'h11, 1'b1, 1'b0, 8'h00, "R8 R11 ring2 untouched");
        run_op(3'd6, 2'd0, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R8 unknown code");
        check(n_lease == l0, "R8 no lease on refusal", n_lease - l0, 0);

        check(n_bad_lease == 0, "R9 cycles under lease", n_bad_lease, 0);
        check(n_unstable == 0, "R10 cycle request stable", n_unstable, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

endmodule